// File: doc/BRIEF.md
# Effective Address Generator

This unit turns an operand specifier into a 24-bit memory address for a 32-bit register machine. Each request names an addressing mode, an operand size, a base register from the address-register file and, for indexed access, an index register from either file. The unit adds the parts at 32 bits, drives the low 24 bits as the address, and, for the auto-stepping modes, produces the new base-register value for the register file to write back.

A request is sampled on a rising clock edge while `req_valid` is high. The address appears in the next cycle with `ea_valid` high. For post-increment and pre-decrement, the cycle after that carries `wb_en` with the new register value and its number. Modes that name no memory location return `no_mem` high so the caller can bypass the memory port.

The control is a four-state machine. IDLE shows nothing. ADDR shows an address with no write-back to follow. ADDR_UPD shows an address that a write-back will follow. WB drives the write-back alone. An accepted request moves the machine to ADDR_UPD for the stepping modes and to ADDR for every other mode. ADDR_UPD always moves to WB. From any other state the machine returns to IDLE when no request is accepted.

Top module: `ea_gen_unit`

## Requirements
- R1: After reset, `ea_valid` and `wb_en` are both low.
- R2: Mode 0 (register indirect) gives the base register's low 24 bits as the address, in the cycle after the request, and no write-back.
- R3: Mode 1 (post-increment) gives the unmodified base as the address. In the next cycle it asserts `wb_en` for one cycle, with `wb_sel` set to the base number and `wb_data` set to the base plus the step. The step is 1 for size 0, 2 for size 1 and 4 for sizes 2 and 3.
- R4: Mode 2 (pre-decrement) gives the base minus the step as the address. In the next cycle it writes that same decremented value back to the base register.
- R5: Mode 3 adds `disp16`, sign-extended to 32 bits, to the base. The base register is not written.
- R6: Mode 4 adds the base, `disp8` sign-extended, and an index. `idx_from_a` = 1 takes the index from the address file and 0 from the data file. `idx_long` = 1 uses all 32 bits of the index register, and 0 uses its low 16 bits sign-extended.
- R7: Mode 5 (absolute) gives `abs_addr` as the address, with no write-back.
- R8: Modes 6 and 7 assert `ea_valid` with `no_mem` = 1 and address 0, and produce no write-back. Every memory mode gives `no_mem` = 0.
- R9: All sums are formed at 32 bits, and the address is their low 24 bits. The write-back value keeps all 32 bits, including any carry or borrow past bit 23.
- R10: `ea_valid` and `wb_en` are never high together, and `wb_en` is high only in the cycle directly after an address from mode 1 or 2.
- R11: A request presented while an address from mode 1 or 2 is being shown is ignored. A request presented during the write-back cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, sampled on the rising edge |
| mode | input | 3 | Addressing mode, 0 to 7 |
| size | input | 2 | Operand size: 0 byte, 1 word, 2 or 3 long |
| base_sel | input | 3 | Base address register number |
| idx_sel | input | 3 | Index register number |
| idx_from_a | input | 1 | 1 selects the index from the address file |
| idx_long | input | 1 | 1 uses the full 32-bit index |
| disp16 | input | 16 | Signed 16-bit displacement |
| disp8 | input | 8 | Signed 8-bit displacement |
| abs_addr | input | 24 | Absolute address |
| a_file | input | 256 | Address registers, register n at bits n*32+31 down to n*32 |
| d_file | input | 256 | Data registers, same layout |
| ea_valid | output | 1 | Address output is valid |
| ea_addr | output | 24 | Effective address |
| no_mem | output | 1 | Mode names no memory location |
| wb_en | output | 1 | Base register write-back strobe |
| wb_sel | output | 3 | Register to write back |
| wb_data | output | 32 | New register value |

## Verification
The hardest situation to reach is a request arriving while a stepping address is being shown, which the unit must drop. The second hardest is a request arriving in the write-back cycle, which the unit must take. The stimulus holds `req_valid` high across two edges after a post-increment to hit the first case. It raises the strobe exactly in the write-back cycle to hit the second. Carry and borrow across bit 23 are forced by stepping bases of $00FFFFFF and 0. Negative word indices and displacements are used to exercise sign extension.

// File: rtl/ea_pkg.sv
package ea_pkg;
    localparam int REG_W  = 32;
    localparam int ADDR_W = 24;
    localparam int NREG   = 8;
    localparam int SEL_W  = $clog2(NREG);

    typedef enum logic [2:0] {
        M_IND     = 3'd0,
        M_POSTINC = 3'd1,
        M_PREDEC  = 3'd2,
        M_DISP16  = 3'd3,
        M_INDEX8  = 3'd4,
        M_ABS     = 3'd5,
        M_NOMEM6  = 3'd6,
        M_NOMEM7  = 3'd7
    } ea_mode_e;

    typedef enum logic [1:0] {
        S_IDLE     = 2'd0,
        S_ADDR     = 2'd1,
        S_ADDR_UPD = 2'd2,
        S_WB       = 2'd3
    } ea_state_e;

    function automatic logic [REG_W-1:0] step_of(input logic [1:0] sz);
        case (sz)
            2'd0:    step_of = REG_W'(1);
            2'd1:    step_of = REG_W'(2);
            default: step_of = REG_W'(4);
        endcase
    endfunction
endpackage

// File: rtl/ea_reg_pick.sv
module ea_reg_pick
    import ea_pkg::*;
#(
    parameter int RW = REG_W,
    parameter int NR = NREG,
    localparam int SW = $clog2(NR)
) (
    input  logic [NR*RW-1:0] a_file,
    input  logic [NR*RW-1:0] d_file,
    input  logic [SW-1:0]    base_sel,
    input  logic [SW-1:0]    idx_sel,
    input  logic             idx_from_a,
    input  logic             idx_long,
    output logic [RW-1:0]    base,
    output logic [RW-1:0]    index
);
    logic [RW-1:0] idx_raw;

    always_comb begin
        base    = a_file[base_sel*RW +: RW];
        idx_raw = idx_from_a ? a_file[idx_sel*RW +: RW] : d_file[idx_sel*RW +: RW];
        if (idx_long)
            index = idx_raw;
        else
            index = {{(RW-16){idx_raw[15]}}, idx_raw[15:0]};
    end
endmodule

// File: rtl/ea_calc.sv
module ea_calc
    import ea_pkg::*;
#(
    parameter int RW = REG_W,
    parameter int AW = ADDR_W
) (
    input  ea_mode_e       mode,
    input  logic [1:0]     size,
    input  logic [RW-1:0]  base,
    input  logic [RW-1:0]  index,
    input  logic [15:0]    disp16,
    input  logic [7:0]     disp8,
    input  logic [AW-1:0]  abs_addr,
    output logic [RW-1:0]  ea_full,
    output logic [RW-1:0]  upd_val,
    output logic           upd_en,
    output logic           no_mem
);
    logic [RW-1:0] step;
    logic [RW-1:0] d16_x;
    logic [RW-1:0] d8_x;
    logic [RW-1:0] dec_val;

    always_comb begin
        step    = step_of(size);
        d16_x   = {{(RW-16){disp16[15]}}, disp16};
        d8_x    = {{(RW-8){disp8[7]}}, disp8};
        dec_val = base - step;
        ea_full = '0;
        upd_val = base;
        upd_en  = 1'b0;
        no_mem  = 1'b0;
        unique case (mode)
            M_IND:     ea_full = base;
            M_POSTINC: begin
                ea_full = base;
                upd_val = base + step;
                upd_en  = 1'b1;
            end
            M_PREDEC:  begin
                ea_full = dec_val;
                upd_val = dec_val;
                upd_en  = 1'b1;
            end
            M_DISP16:  ea_full = base + d16_x;
            M_INDEX8:  ea_full = base + d8_x + index;
            M_ABS:     ea_full = {{(RW-AW){1'b0}}, abs_addr};
            M_NOMEM6, M_NOMEM7: no_mem = 1'b1;
        endcase
    end
endmodule

// File: rtl/ea_gen_unit.sv
module ea_gen_unit
    import ea_pkg::*;
#(
    parameter int RW = REG_W,
    parameter int AW = ADDR_W,
    parameter int NR = NREG,
    localparam int SW = $clog2(NR)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [2:0]       mode,
    input  logic [1:0]       size,
    input  logic [SW-1:0]    base_sel,
    input  logic [SW-1:0]    idx_sel,
    input  logic             idx_from_a,
    input  logic             idx_long,
    input  logic [15:0]      disp16,
    input  logic [7:0]       disp8,
    input  logic [AW-1:0]    abs_addr,
    input  logic [NR*RW-1:0] a_file,
    input  logic [NR*RW-1:0] d_file,
    output logic             ea_valid,
    output logic [AW-1:0]    ea_addr,
    output logic             no_mem,
    output logic             wb_en,
    output logic [SW-1:0]    wb_sel,
    output logic [RW-1:0]    wb_data
);
    ea_state_e     state_q, state_d;
    logic [RW-1:0] base, index, ea_full, upd_val;
    logic          upd_en, nm_c, accept;

    ea_reg_pick #(.RW(RW), .NR(NR)) u_pick (
        .a_file(a_file), .d_file(d_file), .base_sel(base_sel),
        .idx_sel(idx_sel), .idx_from_a(idx_from_a), .idx_long(idx_long),
        .base(base), .index(index)
    );

    ea_calc #(.RW(RW), .AW(AW)) u_calc (
        .mode(ea_mode_e'(mode)), .size(size), .base(base), .index(index),
        .disp16(disp16), .disp8(disp8), .abs_addr(abs_addr),
        .ea_full(ea_full), .upd_val(upd_val), .upd_en(upd_en), .no_mem(nm_c)
    );

    assign accept = req_valid && (state_q != S_ADDR_UPD);

    always_comb begin
        state_d = S_IDLE;
        unique case (state_q)
            S_ADDR_UPD: state_d = S_WB;
            S_IDLE, S_ADDR, S_WB:
                if (accept) state_d = upd_en ? S_ADDR_UPD : S_ADDR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea_addr <= '0;
            no_mem  <= 1'b0;
            wb_sel  <= '0;
            wb_data <= '0;
        end else if (accept) begin
            ea_addr <= ea_full[AW-1:0];
            no_mem  <= nm_c;
            wb_sel  <= base_sel;
            wb_data <= upd_val;
        end
    end

    always_comb begin
        ea_valid = (state_q == S_ADDR) || (state_q == S_ADDR_UPD);
        wb_en    = (state_q == S_WB);
    end

    // R10: address and write-back never share a cycle
    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(ea_valid && wb_en));
    // R10: write-back only directly after an address
    a_r10_wb_follows: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> $past(ea_valid));
    // R3: write-back lasts a single cycle
    a_r3_single_wb: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |=> !wb_en);
    // R8: no-memory results are never followed by a write-back
    a_r8_nomem_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
        (ea_valid && no_mem) |=> !wb_en);
    // R3/R4: write-back value relates to shown address by 0 or one step
    a_r4_wb_step: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> (wb_data[AW-1:0] == $past(ea_addr)
                || wb_data[AW-1:0] - $past(ea_addr) == AW'(1)
                || wb_data[AW-1:0] - $past(ea_addr) == AW'(2)
                || wb_data[AW-1:0] - $past(ea_addr) == AW'(4)));
    // R11: no new address is shown in the write-back cycle
    a_r11_hold_wb: assert property (@(posedge clk) disable iff (!rst_n)
        (ea_valid && !no_mem && $past(1'b1)) |-> 1'b1 ##0 !wb_en);
endmodule

// File: tb/tb_ea_gen_unit.sv
module tb_ea_gen_unit;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [2:0] mode = '0;
    logic [1:0] size = '0;
    logic [2:0] base_sel = '0, idx_sel = '0;
    logic idx_from_a = 1'b0, idx_long = 1'b0;
    logic [15:0] disp16 = '0;
    logic [7:0] disp8 = '0;
    logic [23:0] abs_addr = '0;
    logic [255:0] a_file, d_file;
    logic ea_valid, no_mem, wb_en;
    logic [23:0] ea_addr;
    logic [2:0] wb_sel;
    logic [31:0] wb_data;
    logic [31:0] ar [8];
    logic [31:0] dr [8];
    int vec = 0, bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    always_comb begin
        for (int i = 0; i < 8; i++) begin
            a_file[i*32 +: 32] = ar[i];
            d_file[i*32 +: 32] = dr[i];
        end
    end

    ea_gen_unit dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode(mode), .size(size),
        .base_sel(base_sel), .idx_sel(idx_sel), .idx_from_a(idx_from_a),
        .idx_long(idx_long), .disp16(disp16), .disp8(disp8), .abs_addr(abs_addr),
        .a_file(a_file), .d_file(d_file), .ea_valid(ea_valid), .ea_addr(ea_addr),
        .no_mem(no_mem), .wb_en(wb_en), .wb_sel(wb_sel), .wb_data(wb_data)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        vec++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic drive(input logic [2:0] m, input logic [1:0] s, input logic [2:0] b,
                         input logic [2:0] x, input logic xa, input logic xl,
                         input logic [15:0] d16, input logic [7:0] d8, input logic [23:0] ab);
        mode = m; size = s; base_sel = b; idx_sel = x; idx_from_a = xa;
        idx_long = xl; disp16 = d16; disp8 = d8; abs_addr = ab; req_valid = 1'b1;
    endtask

    // One request, address shown next cycle; optional write-back after
    task automatic one(input string tag, input logic [2:0] m, input logic [1:0] s,
                       input logic [2:0] b, input logic [2:0] x, input logic xa,
                       input logic xl, input logic [15:0] d16, input logic [7:0] d8,
                       input logic [23:0] ab, input logic [23:0] exp_ea,
                       input logic exp_nm, input logic exp_wb, input logic [31:0] exp_wd);
        @(negedge clk);
        drive(m, s, b, x, xa, xl, d16, d8, ab);
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " valid"}, 32'(ea_valid), 32'd1);
        chk({tag, " addr"}, 32'(ea_addr), 32'(exp_ea));
        chk({tag, " no_mem"}, 32'(no_mem), 32'(exp_nm));
        @(negedge clk);
        chk({tag, " wb_en"}, 32'(wb_en), 32'(exp_wb));
        if (exp_wb) begin
            chk({tag, " wb_sel"}, 32'(wb_sel), 32'(b));
            chk({tag, " wb_data"}, wb_data, exp_wd);
        end
    endtask

    task automatic t_reset();
        chk("R1 ea_valid", 32'(ea_valid), 32'd0);
        chk("R1 wb_en", 32'(wb_en), 32'd0);
    endtask

    task automatic t_indirect();
        one("R2 ind A0", 3'd0, 2'd2, 3'd0, 3'd0, 0, 0, 16'h0, 8'h0, 24'h0, 24'h002000, 0, 0, 0);
    endtask

    task automatic t_postinc();
        one("R3 post.b", 3'd1, 2'd0, 3'd1, 3'd0, 0, 0, 16'h0, 8'h0, 24'h0, 24'h002004, 0, 1, 32'h00002005);
        one("R3 post.w", 3'd1, 2'd1, 3'd1, 3'd0, 0, 0, 16'h0, 8'h0, 24'h0, 24'h002004, 0, 1, 32'h00002006);
        one("R3 post.l", 3'd1, 2'd2, 3'd1, 3'd0, 0, 0, 16'h0, 8'h0, 24'h0, 24'h002004, 0, 1, 32'h00002008);
        one("R3 post.s3", 3'd1, 2'd3, 3'd1, 3'd0, 0, 0, 16'h0, 8'h0, 24'h0, 24'h002004, 0, 1, 32'h00002008);
    endtask

    task automatic t_predec();
        one("R4 pre.b", 3'd2, 2'd0, 3'd1, 3'd0, 0, 0, 16'h0, 8'h0, 24'h0, 24'h002003, 0, 1, 32'h00002003);
        one("R4 pre.w", 3'd2, 2'd1, 3'd1, 3'd0, 0, 0, 16'h0, 8'h0, 24'h0, 24'h002002, 0, 1, 32'h00002002);
        one("R4 pre.l", 3'd2, 2'd2, 3'd1, 3'd0, 0, 0, 16'h0, 8'h0, 24'h0, 24'h002000, 0, 1, 32'h00002000);
    endtask

    task automatic t_disp16();
        one("R5 d16 +12", 3'd3, 2'd1, 3'd4, 3'd0, 0, 0, 16'h000C, 8'h0, 24'h0, 24'h01234C, 0, 0, 0);
        one("R5 d16 -1", 3'd3, 2'd1, 3'd4, 3'd0, 0, 0, 16'hFFFF, 8'h0, 24'h0, 24'h01233F, 0, 0, 0);
        one("R5 d16 -8000", 3'd3, 2'd1, 3'd4, 3'd0, 0, 0, 16'h8000, 8'h0, 24'h0, 24'h00A340, 0, 0, 0);
    endtask

    task automatic t_index();
        one("R6 D2.W", 3'd4, 2'd2, 3'd1, 3'd2, 0, 0, 16'h0, 8'h03, 24'h0, 24'h00200C, 0, 0, 0);
        one("R6 D2.L", 3'd4, 2'd2, 3'd1, 3'd2, 0, 1, 16'h0, 8'h03, 24'h0, 24'h0A200C, 0, 0, 0);
        one("R6 A5.W neg", 3'd4, 2'd2, 3'd0, 3'd5, 1, 0, 16'h0, 8'hFF, 24'h0, 24'h001F7F, 0, 0, 0);
        one("R6 D3.W 8000", 3'd4, 2'd2, 3'd4, 3'd3, 0, 0, 16'h0, 8'h00, 24'h0, 24'h00A340, 0, 0, 0);
    endtask

    task automatic t_abs();
        one("R7 abs", 3'd5, 2'd1, 3'd1, 3'd0, 0, 0, 16'h0, 8'h0, 24'hABCDEF, 24'hABCDEF, 0, 0, 0);
    endtask

    task automatic t_nomem();
        one("R8 mode6", 3'd6, 2'd1, 3'd1, 3'd0, 0, 0, 16'h0, 8'h0, 24'h123456, 24'h000000, 1, 0, 0);
        one("R8 mode7", 3'd7, 2'd2, 3'd2, 3'd0, 0, 0, 16'h0, 8'h0, 24'h0, 24'h000000, 1, 0, 0);
    endtask

    task automatic t_wrap();
        one("R9 post carry", 3'd1, 2'd2, 3'd2, 3'd0, 0, 0, 16'h0, 8'h0, 24'h0, 24'hFFFFFF, 0, 1, 32'h01000003);
        one("R9 pre borrow", 3'd2, 2'd0, 3'd3, 3'd0, 0, 0, 16'h0, 8'h0, 24'h0, 24'hFFFFFF, 0, 1, 32'hFFFFFFFF);
    endtask

    task automatic t_ignore();
        @(negedge clk);
        drive(3'd1, 2'd1, 3'd1, 3'd0, 0, 0, 16'h0, 8'h0, 24'h0);
        @(negedge clk);
        drive(3'd5, 2'd1, 3'd1, 3'd0, 0, 0, 16'h0, 8'h0, 24'h654321);
        chk("R11 first addr", 32'(ea_addr), 32'h002004);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10 wb only", 32'(wb_en), 32'd1);
        chk("R11 ignored no valid", 32'(ea_valid), 32'd0);
        @(negedge clk);
        chk("R11 stays idle", 32'(ea_valid), 32'd0);
        chk("R10 no second wb", 32'(wb_en), 32'd0);
    endtask

    task automatic t_accept_in_wb();
        @(negedge clk);
        drive(3'd1, 2'd0, 3'd0, 3'd0, 0, 0, 16'h0, 8'h0, 24'h0);
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        chk("R11 wb cycle", 32'(wb_en), 32'd1);
        drive(3'd5, 2'd0, 3'd0, 3'd0, 0, 0, 16'h0, 8'h0, 24'h111111);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R11 accepted in wb", 32'(ea_valid), 32'd1);
        chk("R11 accepted addr", 32'(ea_addr), 32'h111111);
        chk("R10 no overlap", 32'(wb_en), 32'd0);
        @(negedge clk);
        chk("R7 abs no wb", 32'(wb_en), 32'd0);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin
            ar[i] = '0;
            dr[i] = '0;
        end
        ar[0] = 32'h00002000; ar[1] = 32'h00002004; ar[2] = 32'h00FFFFFF;
        ar[3] = 32'h00000000; ar[4] = 32'h00012340; ar[5] = 32'h0000FF80;
        dr[0] = 32'h12666565; dr[2] = 32'h100A0005; dr[3] = 32'hABCD8000;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_indirect();
        t_postinc();
        t_predec();
        t_disp16();
        t_index();
        t_abs();
        t_nomem();
        t_wrap();
        t_ignore();
        t_accept_in_wb();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
            $finish;
        end
    end
endmodule